// File: doc/BRIEF.md
# Watchdog Timer with Selectable Unit and Reset Style

This block is a watchdog device for a system-management chip. Software programs an 8-bit timeout, picks seconds or minutes as its unit, and arms the counter. A free-running 1 ms tick input drives a two-stage prescaler, which makes one decrement per second or per minute. If software does not rewrite the timeout before the count runs out, the block pulls an active-low system reset output low. The output stays low as a held level, or it drops for one of four encoded pulse widths. A sticky status bit records that a timeout happened, so software can find out after the system restarts why the restart occurred.

Software reaches the block through a byte-wide register port with write and read strobes and an 8-bit address. An external logical-device enable input gates the whole countdown, together with the enable bit in the control register. Every write to the timeout register is a keepalive. It reloads the count and restarts the prescaler.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `wdrst_n_o` is 1, and reads of addresses 0xF0, 0xF5 and 0xF6 return 0x00.
- R2: The registers read back as follows. 0xF0 bit 7 is the output enable. 0xF5 has bit 4 for pulse style, bit 3 for minutes unit and bits 1:0 for the width code, with bits 7, 6 and 2 reading 0. 0xF6 is the 8-bit timeout. `rdata_o` shows the addressed value one cycle after `rd_i`.
- R3: The countdown runs only while both `ld_en_i` and 0xF5 bit 5 (written as enable) are 1. At any other time there is no expiry, and the count is held at the 0xF6 value.
- R4: In seconds unit (0xF5 bit 3 = 0), a timeout N ≥ 1 expires on the N·TICKS_PER_SEC-th tick after arming or after a keepalive.
- R5: In minutes unit (0xF5 bit 3 = 1), a timeout N ≥ 1 expires on the N·TICKS_PER_SEC·SECS_PER_MIN-th tick.
- R6: A timeout of 0 expires on the first tick after arming.
- R7: A write to 0xF6 is a keepalive. It reloads the count with the written value and restarts the prescaler. If it falls in the same cycle as an expiring tick, the keepalive wins and no expiry occurs.
- R8: In level style (0xF5 bit 4 = 0), `wdrst_n_o` goes low at expiry. It stays low until the countdown is disarmed (0xF5 bit 5 written 0 or `ld_en_i` low) or a keepalive arrives.
- R9: In pulse style, `wdrst_n_o` goes low at expiry for W ticks, where W depends on the width code: code 0 gives PW0, 1 gives PW1, 2 gives PW2 and 3 gives PW3 (defaults 1, 25, 125 and 5000 ms). It then returns high and does not pulse again until the counter is re-armed.
- R10: With 0xF0 bit 7 at 0, `wdrst_n_o` stays 1 through an expiry, but the status is still set.
- R11: Expiry sets the status, which reads as 0xF5 bit 5. The status stays set when the countdown is disarmed. A write of 0xF5 with bit 5 = 1 while the enable is 0 clears it (and arms the counter). The same write while the enable is 1 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| ld_en_i | input | 1 | Logical-device enable |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| wdrst_n_o | output | 1 | Active-low watchdog reset output |

## Verification
A keepalive write and the tick that would finish the count can land on the same clock edge. That is the collision that matters most for this block. The bench arms a one-second timeout and lets one tick fewer than the expiry count pass. It then raises the tick and writes the timeout register in the same cycle. The reset output must stay high at that point, and the expiry must then come exactly one full period later. That result shows the reload took priority and the prescaler restarted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] A_OUTCFG = 8'hF0;
  localparam logic [7:0] A_CTL    = 8'hF5;
  localparam logic [7:0] A_TIME   = 8'hF6;

  localparam int B_OE    = 7;
  localparam int B_EN    = 5;
  localparam int B_PULSE = 4;
  localparam int B_UNIT  = 3;

  typedef struct packed {
    logic       pulse;
    logic       unit_min;
    logic [1:0] wcode;
  } ctl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       sts_i,
  output logic [7:0] rdata_o,
  output logic       oe_o,
  output logic       en_o,
  output ctl_t       ctl_o,
  output logic [7:0] time_o,
  output logic       ka_o,
  output logic [7:0] ka_val_o,
  output logic       sts_clr_o
);
  logic       oe_q, oe_d;
  logic       en_q, en_d;
  ctl_t       ctl_q, ctl_d;
  logic [7:0] time_q, time_d;
  logic [7:0] rdata_q, rdata_d;
  logic [7:0] rmux;
  logic       wr_out, wr_ctl, wr_time;

  always_comb begin
    wr_out  = wr_i && (addr_i == A_OUTCFG);
    wr_ctl  = wr_i && (addr_i == A_CTL);
    wr_time = wr_i && (addr_i == A_TIME);

    oe_d   = oe_q;
    en_d   = en_q;
    ctl_d  = ctl_q;
    time_d = time_q;
    if (wr_out) oe_d = wdata_i[B_OE];
    if (wr_ctl) begin
      en_d           = wdata_i[B_EN];
      ctl_d.pulse    = wdata_i[B_PULSE];
      ctl_d.unit_min = wdata_i[B_UNIT];
      ctl_d.wcode    = wdata_i[1:0];
    end
    if (wr_time) time_d = wdata_i;

    unique case (addr_i)
      A_OUTCFG: rmux = {oe_q, 7'b0};
      A_CTL:    rmux = {2'b00, sts_i, ctl_q.pulse, ctl_q.unit_min, 1'b0, ctl_q.wcode};
      A_TIME:   rmux = time_q;
      default:  rmux = 8'h00;
    endcase
    rdata_d = rd_i ? rmux : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      oe_q    <= 1'b0;
      en_q    <= 1'b0;
      ctl_q   <= '0;
      time_q  <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      oe_q    <= oe_d;
      en_q    <= en_d;
      ctl_q   <= ctl_d;
      time_q  <= time_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o   = rdata_q;
  assign oe_o      = oe_q;
  assign en_o      = en_q;
  assign ctl_o     = ctl_q;
  assign time_o    = time_q;
  assign ka_o      = wr_time;
  assign ka_val_o  = wdata_i;
  assign sts_clr_o = wr_ctl && wdata_i[B_EN] && !en_q;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tick_i,
  input  logic restart_i,
  input  logic unit_min_i,
  output logic unit_tick_o
);
  localparam int MSW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int SSW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [MSW-1:0] MS_LAST  = MSW'(TICKS_PER_SEC - 1);
  localparam logic [SSW-1:0] SEC_LAST = SSW'(SECS_PER_MIN - 1);

  logic [MSW-1:0] ms_q, ms_d;
  logic [SSW-1:0] sec_q, sec_d;
  logic           sec_pulse, min_pulse;

  always_comb begin
    sec_pulse = tick_i && (ms_q == MS_LAST);
    min_pulse = sec_pulse && (sec_q == SEC_LAST);
    ms_d  = ms_q;
    sec_d = sec_q;
    if (restart_i) begin
      ms_d  = '0;
      sec_d = '0;
    end else begin
      if (tick_i)    ms_d  = sec_pulse ? '0 : ms_q + 1'b1;
      if (sec_pulse) sec_d = min_pulse ? '0 : sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      ms_q  <= ms_d;
      sec_q <= sec_d;
    end
  end

  assign unit_tick_o = !restart_i && (unit_min_i ? min_pulse : sec_pulse);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int PW0 = 1,
  parameter int PW1 = 25,
  parameter int PW2 = 125,
  parameter int PW3 = 5000
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       tick_i,
  input  logic       unit_tick_i,
  input  logic       arm_i,
  input  logic       ka_i,
  input  logic [7:0] ka_val_i,
  input  logic [7:0] time_i,
  input  ctl_t       ctl_i,
  input  logic       sts_clr_i,
  output logic       expire_o,
  output logic       fired_o,
  output logic       sts_o,
  output logic [7:0] cnt_o,
  output logic       drive_low_o
);
  localparam int PW_TAB [4] = '{PW0, PW1, PW2, PW3};
  localparam int PW_A   = (PW0 > PW1) ? PW0 : PW1;
  localparam int PW_B   = (PW2 > PW3) ? PW2 : PW3;
  localparam int PW_MAX = (PW_A > PW_B) ? PW_A : PW_B;
  localparam int PCW    = $clog2(PW_MAX + 1);

  logic [7:0]     cnt_q, cnt_d;
  logic           fired_q, fired_d;
  logic           sts_q, sts_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           expire, zero_hit, last_hit;

  always_comb begin
    zero_hit = tick_i && (cnt_q == 8'd0);
    last_hit = unit_tick_i && (cnt_q == 8'd1);
    expire   = arm_i && !fired_q && !ka_i && (zero_hit || last_hit);

    cnt_d = cnt_q;
    if (ka_i)                                           cnt_d = ka_val_i;
    else if (!arm_i)                                    cnt_d = time_i;
    else if (!fired_q && unit_tick_i && cnt_q != 8'd0)  cnt_d = cnt_q - 8'd1;

    fired_d = fired_q;
    if (!arm_i || ka_i) fired_d = 1'b0;
    else if (expire)    fired_d = 1'b1;

    sts_d = sts_q;
    if (expire)         sts_d = 1'b1;
    else if (sts_clr_i) sts_d = 1'b0;

    pcnt_d = pcnt_q;
    if (expire && ctl_i.pulse)              pcnt_d = PCW'(PW_TAB[ctl_i.wcode]);
    else if (tick_i && pcnt_q != '0)        pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q   <= 8'h00;
      fired_q <= 1'b0;
      sts_q   <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      sts_q   <= sts_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign expire_o    = expire;
  assign fired_o     = fired_q;
  assign sts_o       = sts_q;
  assign cnt_o       = cnt_q;
  assign drive_low_o = (fired_q && !ctl_i.pulse) || (pcnt_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60,
  parameter int PW0 = 1,
  parameter int PW1 = 25,
  parameter int PW2 = 125,
  parameter int PW3 = 5000
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       tick_i,
  input  logic       ld_en_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       wdrst_n_o
);
  logic       oe, en, arm, ka, sts_clr, sts, expire, fired, unit_tick, drive_low;
  logic [7:0] time_v, ka_val, cnt;
  ctl_t       ctl;

  wdog_regs regs_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .sts_i(sts), .rdata_o(rdata_o),
    .oe_o(oe), .en_o(en), .ctl_o(ctl), .time_o(time_v), .ka_o(ka),
    .ka_val_o(ka_val), .sts_clr_o(sts_clr)
  );

  assign arm = ld_en_i && en;

  wdog_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)) pre_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(tick_i),
    .restart_i(!arm || ka), .unit_min_i(ctl.unit_min), .unit_tick_o(unit_tick)
  );

  wdog_core #(.PW0(PW0), .PW1(PW1), .PW2(PW2), .PW3(PW3)) core_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(tick_i), .unit_tick_i(unit_tick),
    .arm_i(arm), .ka_i(ka), .ka_val_i(ka_val), .time_i(time_v), .ctl_i(ctl),
    .sts_clr_i(sts_clr), .expire_o(expire), .fired_o(fired), .sts_o(sts),
    .cnt_o(cnt), .drive_low_o(drive_low)
  );

  assign wdrst_n_o = !(oe && drive_low);
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wdrst_n,
  input logic       oe,
  input logic       arm,
  input logic       expire,
  input logic       sts,
  input logic       sts_clr,
  input logic       ka,
  input logic [7:0] ka_val,
  input logic [7:0] cnt,
  input logic       fired
);
  // R10
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !wdrst_n |-> oe);
  // R11
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n) expire |=> sts);
  // R11
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (sts && !sts_clr) |=> sts);
  // R3
  idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n) !arm |-> !expire);
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n) ka |=> (cnt == $past(ka_val)));
  // R8
  disarm_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !arm |=> !fired);
endmodule

bind wdog_timer wdog_chk chk_i (
  .clk(clk_i), .rst_n(rst_n_i), .wdrst_n(wdrst_n_o), .oe(oe), .arm(arm),
  .expire(expire), .sts(sts), .sts_clr(sts_clr), .ka(ka), .ka_val(ka_val),
  .cnt(cnt), .fired(fired)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb_top;
  localparam int TPS = 4;
  localparam int SPM = 3;

  logic       clk = 1'b0;
  logic       rst_n, tick, ld_en, wr, rd;
  logic [7:0] addr, wdata, rdata;
  logic       wdrst_n;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  // {unit[24], timeout[23:16], ticks to expiry[15:0]} with TPS=4, SPM=3
  localparam logic [31:0] VEC [7] = '{
    {7'd0, 1'b0, 8'd2, 16'd8},
    {7'd0, 1'b0, 8'd1, 16'd4},
    {7'd0, 1'b1, 8'd1, 16'd12},
    {7'd0, 1'b1, 8'd2, 16'd24},
    {7'd0, 1'b0, 8'd0, 16'd1},
    {7'd0, 1'b1, 8'd0, 16'd1},
    {7'd0, 1'b0, 8'd5, 16'd20}
  };

  always #4 clk = ~clk;

  wdog_timer #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM),
               .PW0(1), .PW1(3), .PW2(5), .PW3(7)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick), .ld_en_i(ld_en),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .wdrst_n_o(wdrst_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; tick = 1'b0; ld_en = 1'b1; wr = 1'b0; rd = 1'b0;
    addr = 8'h00; wdata = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 wdrst_n", wdrst_n, 1);
    rd_reg(8'hF0, r); chk("R1 F0", r, 8'h00);
    rd_reg(8'hF5, r); chk("R1 F5", r, 8'h00);
    rd_reg(8'hF6, r); chk("R1 F6", r, 8'h00);

    // R2 readback
    wr_reg(8'hF0, 8'hFF);
    wr_reg(8'hF5, 8'h1B);
    wr_reg(8'hF6, 8'h5A);
    rd_reg(8'hF0, r); chk("R2 F0", r, 8'h80);
    rd_reg(8'hF5, r); chk("R2 F5", r, 8'h1B);
    rd_reg(8'hF6, r); chk("R2 F6", r, 8'h5A);
    wr_reg(8'hF5, 8'h00);

    // R4 R5 R6 vector walk, level style, output enabled
    foreach (VEC[v]) begin
      wr_reg(8'hF5, 8'h00);
      wr_reg(8'hF6, VEC[v][23:16]);
      wr_reg(8'hF5, 8'h20 | (8'(VEC[v][24]) << 3));
      ticks(int'(VEC[v][15:0]) - 1);
      chk("R4/R5/R6 before expiry", wdrst_n, 1);
      ticks(1);
      chk("R4/R5/R6 at expiry", wdrst_n, 0);
      rd_reg(8'hF5, r);
      chk("R11 status after expiry", r, 8'h20 | (8'(VEC[v][24]) << 3));
    end

    // R3 gating by ld_en_i
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF6, 8'd1);
    ld_en = 1'b0;
    wr_reg(8'hF5, 8'h20);
    ticks(12);
    chk("R3 no expiry while ld_en low", wdrst_n, 1);
    rd_reg(8'hF5, r); chk("R3 status clear while disarmed", r, 8'h00);
    ld_en = 1'b1;
    ticks(3);
    chk("R3 counting after ld_en", wdrst_n, 1);
    ticks(1);
    chk("R3 expiry after ld_en", wdrst_n, 0);

    // R8 level held, released by disarm
    ticks(5);
    chk("R8 level held", wdrst_n, 0);
    ld_en = 1'b0;
    idle(2);
    chk("R8 released by ld_en low", wdrst_n, 1);
    wr_reg(8'hF5, 8'h00);
    ld_en = 1'b1;

    // R11 sticky status
    rd_reg(8'hF5, r); chk("R11 status kept when disarmed", r, 8'h20);
    wr_reg(8'hF5, 8'h20);
    rd_reg(8'hF5, r); chk("R11 cleared by write while disabled", r, 8'h00);
    ticks(4);
    chk("R8 level expiry", wdrst_n, 0);
    wr_reg(8'hF5, 8'h20);
    rd_reg(8'hF5, r); chk("R11 not cleared while enabled", r, 8'h20);
    wr_reg(8'hF5, 8'h00);
    idle(1);
    chk("R8 released by enable clear", wdrst_n, 1);

    // R7 keepalive
    wr_reg(8'hF6, 8'd2);
    wr_reg(8'hF5, 8'h20);
    ticks(6);
    wr_reg(8'hF6, 8'd2);
    ticks(7);
    chk("R7 keepalive postpones", wdrst_n, 1);
    ticks(1);
    chk("R7 expiry after reload", wdrst_n, 0);

    // R7 keepalive colliding with expiring tick
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF6, 8'd1);
    wr_reg(8'hF5, 8'h20);
    ticks(3);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 8'hF6; wdata = 8'd1;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    chk("R7 collision keepalive wins", wdrst_n, 1);
    ticks(3);
    chk("R7 full period after collision", wdrst_n, 1);
    ticks(1);
    chk("R7 expiry after collision", wdrst_n, 0);

    // R9 pulse code 1 (W=3)
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF5, 8'h31);
    ticks(4);
    chk("R9 pulse starts", wdrst_n, 0);
    ticks(2);
    chk("R9 pulse code1 still low", wdrst_n, 0);
    ticks(1);
    chk("R9 pulse code1 ends", wdrst_n, 1);
    ticks(10);
    chk("R9 no second pulse", wdrst_n, 1);
    rd_reg(8'hF5, r); chk("R9 status with pulse", r, 8'h31);
    // code 3 (W=7)
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF5, 8'h33);
    ticks(4);
    ticks(6);
    chk("R9 pulse code3 still low", wdrst_n, 0);
    ticks(1);
    chk("R9 pulse code3 ends", wdrst_n, 1);
    // code 0 (W=1)
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF5, 8'h30);
    ticks(4);
    chk("R9 pulse code0 low", wdrst_n, 0);
    ticks(1);
    chk("R9 pulse code0 ends", wdrst_n, 1);

    // R10 output disabled
    wr_reg(8'hF0, 8'h00);
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF5, 8'h20);
    ticks(4);
    chk("R10 output held high", wdrst_n, 1);
    rd_reg(8'hF5, r); chk("R10 status still set", r, 8'h20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule